// File: doc/BRIEF.md
# Serial audio bit and frame clock generator

This block derives the bit clock and the frame (left/right) clock of a serial audio port from the chip clock. Its 16-bit configuration word picks the role (master or slave), the bit-clock divider, the frame length, the frame shape and the polarity of both clocks. As master it drives both clocks and pulses `frame_start` in the first cycle of every frame. As slave it leaves the clock outputs low, resynchronises the incoming clocks and pulses `frame_start` once for each frame it sees.

`clk` is taken to run at twice the system-clock rate. A divider ratio D therefore gives a bit-clock period of 2·D `clk` cycles with 50% duty, and ratio 1 needs no special case. A written word waits in a shadow register. The generator picks it up at the end of the running frame, or on the next edge when the generator is stopped. This stops a divider change from cutting a clock pulse short. Word size (bits 5:4) is kept for the serial data path and has no effect here.

Top module: `aclkgen_top`

## Requirements
- R1: Out of reset the block is a slave: `bclk_oe`, `bclk_out`, `lrck_out`, `frame_start` and `cfg_err` are all 0.
- R2: Bit 15 = 1 selects master. Divider code bits 12:9, values 0..13, give ratios 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192. The bit-clock period is 2·ratio `clk` cycles, and the clock is high for ratio cycles.
- R3: Frame-length code bits 8:6, values 0..4, give 16·2^code bit clocks per frame.
- R4: Format field bits 3:2 = 1 (left-justified) or 2 (right-justified): the frame clock is high for bits 0..N/2-1 and low for the rest of the frame.
- R5: Format 0 (I2S): the frame clock is high for bits N/2-1..N-2 and low for bit N-1 and bits 0..N/2-2, so the left half starts one bit after the clock falls.
- R6: Format 3 (DSP): the frame clock is high for exactly one bit. With bit 14 = 0 that bit is N-1, the bit before the frame; with bit 14 = 1 it is bit 0. Bit 14 never inverts the clock in this format.
- R7: Bit 13 inverts the bit clock: the frame starts with the bit clock at level bit13. In formats 0..2, bit 14 inverts the frame clock.
- R8: In master mode, divider code 14 or 15, or frame-length code 5..7, raises `cfg_err`. Both clocks then stay frozen: the bit clock at bit 13, the frame clock at bit 14 (or 0 in DSP).
- R9: While clocks run, a new word takes effect only at the end of the current frame. While stopped or in slave mode, it takes effect on the next clock edge.
- R10: In master mode `frame_start` is a one-cycle pulse in the first cycle of each frame, once per frame.
- R11: In slave mode `bclk_oe`, `bclk_out` and `lrck_out` are 0. `frame_start` pulses once each time the frame clock, sampled on rising edges of the polarity-adjusted bit clock, becomes active. Active means low for format 0 and high otherwise, after the bit-14 inversion for formats 0..2.
- R12: The word-size field (bits 5:4) changes neither clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, twice the system-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word |
| bclk_in | input | 1 | Bit clock from the far end (slave mode) |
| lrck_in | input | 1 | Frame clock from the far end (slave mode) |
| bclk_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated frame clock |
| bclk_oe | output | 1 | High when the block drives the clocks (master) |
| frame_start | output | 1 | One-cycle pulse per frame |
| cfg_err | output | 1 | Unsupported divider or frame-length code in master mode |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, and counters sized for ratio 192 and 256-bit frames. These defaults bring every legal divider code and every frame length within reach. It sweeps all fourteen ratios, all five frame lengths, and every format under both polarity bits and several word sizes, and it compares frame-clock patterns bit by bit with arithmetic expectations. It also drives slave-mode clock streams in each format and counts the detected frames. Mid-frame writes and reserved codes are used to expose when a new word is applied.

// File: rtl/aclkgen_pkg.sv
package aclkgen_pkg;

  localparam int CFG_W         = 16;
  localparam int MAX_RATIO     = 192;
  localparam int MAX_FRAME     = 256;
  localparam int DIV_CNT_W     = $clog2(MAX_RATIO);
  localparam int IDX_W         = $clog2(MAX_FRAME);
  localparam int RATIO_W       = DIV_CNT_W + 1;
  localparam int FBITS_W       = IDX_W + 4;
  localparam logic [3:0] BDIV_MAX_CODE = 4'd13;
  localparam logic [2:0] FLEN_MAX_CODE = 3'd4;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  // Field order follows the bit positions of the configuration word.
  typedef struct packed {
    logic       master;   // 15
    logic       inv_lr;   // 14
    logic       inv_bit;  // 13
    logic [3:0] bdiv;     // 12:9
    logic [2:0] flen;     // 8:6
    logic [1:0] wsize;    // 5:4
    fmt_e       fmt;      // 3:2
    logic [1:0] spare;    // 1:0
  } cfg_t;

  // Divider ratio: 1, 2, then powers of two on even codes and
  // three times a power of two on odd codes.
  function automatic logic [RATIO_W-1:0] bdiv_ratio(input logic [3:0] code);
    logic [RATIO_W-1:0] r;
    if (code == 4'd0)
      r = RATIO_W'(1);
    else if (code == 4'd1)
      r = RATIO_W'(2);
    else if (!code[0])
      r = RATIO_W'(1) << ({1'b0, code[3:1]} + 4'd1);
    else
      r = RATIO_W'(3) << code[3:1];
    return r;
  endfunction

  function automatic logic [FBITS_W-1:0] frame_bits(input logic [2:0] code);
    return FBITS_W'(16) << code;
  endfunction

  // Frame-clock level (before polarity) for bit index idx of a frame
  // whose last index is last.
  function automatic logic lrck_shape(input fmt_e fmt, input logic dsp_b,
                                      input logic [IDX_W-1:0] idx,
                                      input logic [IDX_W-1:0] last);
    logic [IDX_W-1:0] half;
    logic r;
    half = (last >> 1) + IDX_W'(1);
    case (fmt)
      FMT_I2S: r = (idx >= half - IDX_W'(1)) && (idx != last);
      FMT_DSP: r = dsp_b ? (idx == '0) : (idx == last);
      default: r = (idx < half);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/aclkgen_bitclk.sv
module aclkgen_bitclk #(
  parameter int DIV_W = aclkgen_pkg::DIV_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_last,
  output logic             bclk_r,
  output logic             tick,
  output logic             fall,
  output logic             cnt_zero
);

  logic [DIV_W-1:0] cnt;

  assign tick     = run && (cnt == half_last);
  assign fall     = tick && bclk_r;
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt    <= '0;
      bclk_r <= 1'b0;
    end else if (tick) begin
      cnt    <= '0;
      bclk_r <= ~bclk_r;
    end else begin
      cnt    <= cnt + DIV_W'(1);
    end
  end

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= half_last); // R2

endmodule

// File: rtl/aclkgen_frame.sv
module aclkgen_frame
  import aclkgen_pkg::*;
#(
  parameter int IW = aclkgen_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fall,
  input  logic [IW-1:0] idx_last,
  input  fmt_e          fmt,
  input  logic          dsp_b,
  output logic [IW-1:0] bit_idx,
  output logic          frame_end,
  output logic          lrck_raw
);

  assign frame_end = fall && (bit_idx == idx_last);
  assign lrck_raw  = run && lrck_shape(fmt, dsp_b, bit_idx, idx_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      bit_idx <= '0;
    else if (fall)
      bit_idx <= frame_end ? '0 : bit_idx + IW'(1);
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> bit_idx <= idx_last); // R3

endmodule

// File: rtl/aclkgen_follow.sv
module aclkgen_follow
  import aclkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk_in,
  input  logic lrck_in,
  input  logic inv_bit,
  input  logic inv_lr,
  input  fmt_e fmt,
  output logic hit
);

  localparam int SMSB = SYNC_STAGES - 1;

  logic [SMSB:0] bsync, lsync;
  logic b_now, b_prev, rise, lvl, active, smp;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
          bsync <= '0;
          lsync <= '0;
        end else begin
          bsync <= {bsync[SMSB-1:0], bclk_in};
          lsync <= {lsync[SMSB-1:0], lrck_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
          bsync <= '0;
          lsync <= '0;
        end else begin
          bsync <= bclk_in;
          lsync <= lrck_in;
        end
      end
    end
  endgenerate

  assign b_now  = bsync[SMSB] ^ inv_bit;
  assign rise   = b_now && !b_prev;
  assign lvl    = lsync[SMSB] ^ (inv_lr && (fmt != FMT_DSP));
  assign active = (fmt == FMT_I2S) ? !lvl : lvl;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      b_prev <= 1'b0;
      smp    <= 1'b0;
      hit    <= 1'b0;
    end else begin
      b_prev <= b_now;
      hit    <= rise && active && !smp;
      if (rise)
        smp <= active;
    end
  end

  AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R11

endmodule

// File: rtl/aclkgen_top.sv
module aclkgen_top
  import aclkgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             bclk_in,
  input  logic             lrck_in,
  output logic             bclk_out,
  output logic             lrck_out,
  output logic             bclk_oe,
  output logic             frame_start,
  output logic             cfg_err
);

  cfg_t act_q, pend_q;
  logic pend_vld_q;

  logic codes_ok, running, load_cfg, is_dsp;
  logic bclk_raw, bit_tick, bit_fall, cnt_zero;
  logic frame_end, lrck_raw, slave_hit, master_fs;
  logic [DIV_CNT_W-1:0] half_last;
  logic [IDX_W-1:0]     idx_last, bit_idx;
  logic                 unused_fields;

  assign codes_ok  = (act_q.bdiv <= BDIV_MAX_CODE) && (act_q.flen <= FLEN_MAX_CODE);
  assign running   = act_q.master && codes_ok;
  assign cfg_err   = act_q.master && !codes_ok;
  assign is_dsp    = (act_q.fmt == FMT_DSP);
  assign half_last = DIV_CNT_W'(bdiv_ratio(act_q.bdiv) - RATIO_W'(1));
  assign idx_last  = IDX_W'(frame_bits(act_q.flen) - FBITS_W'(1));
  assign load_cfg  = pend_vld_q && (!running || frame_end);
  assign unused_fields = ^{act_q.wsize, act_q.spare, bit_tick};

  // Shadow register and frame-aligned hand-over.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (load_cfg)
        act_q <= pend_q;
      if (cfg_we) begin
        pend_q     <= cfg_t'(cfg_wdata);
        pend_vld_q <= 1'b1;
      end else if (load_cfg) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  aclkgen_bitclk #(.DIV_W(DIV_CNT_W)) u_bitclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (running),
    .half_last (half_last),
    .bclk_r    (bclk_raw),
    .tick      (bit_tick),
    .fall      (bit_fall),
    .cnt_zero  (cnt_zero)
  );

  aclkgen_frame #(.IW(IDX_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (running),
    .fall      (bit_fall),
    .idx_last  (idx_last),
    .fmt       (act_q.fmt),
    .dsp_b     (act_q.inv_lr),
    .bit_idx   (bit_idx),
    .frame_end (frame_end),
    .lrck_raw  (lrck_raw)
  );

  aclkgen_follow #(.SYNC_STAGES(SYNC_STAGES)) u_follow (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (!act_q.master),
    .bclk_in (bclk_in),
    .lrck_in (lrck_in),
    .inv_bit (act_q.inv_bit),
    .inv_lr  (act_q.inv_lr),
    .fmt     (act_q.fmt),
    .hit     (slave_hit)
  );

  assign master_fs   = running && (bit_idx == '0) && !bclk_raw && cnt_zero;
  assign bclk_oe     = act_q.master;
  assign bclk_out    = act_q.master && (bclk_raw ^ act_q.inv_bit);
  assign lrck_out    = act_q.master && (lrck_raw ^ (act_q.inv_lr && !is_dsp));
  assign frame_start = act_q.master ? master_fs : slave_hit;

  AST_LOAD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && load_cfg) |-> frame_end); // R9

  AST_ERR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err) && !$past(load_cfg)) |->
      ($stable(bclk_out) && $stable(lrck_out))); // R8

  AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && bclk_oe) |=> !frame_start); // R10

endmodule

// File: tb/aclkgen_top_tb.sv
`timescale 1ns/1ps
module aclkgen_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        bclk_in = 1'b0;
  logic        lrck_in = 1'b0;
  logic        bclk_out, lrck_out, bclk_oe, frame_start, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit running_b = 1'b0;
  int ratio_tab [14] = '{1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192};

  always #4 clk = ~clk;

  aclkgen_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .bclk_in     (bclk_in),
    .lrck_in     (lrck_in),
    .bclk_out    (bclk_out),
    .lrck_out    (lrck_out),
    .bclk_oe     (bclk_oe),
    .frame_start (frame_start),
    .cfg_err     (cfg_err)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(bit m, bit il, bit ib, int bd, int fl, int ws, int fm);
    return {m, il, ib, 4'(bd), 3'(fl), 2'(ws), 2'(fm), 2'b00};
  endfunction

  function automatic bit exp_lr(int fm, bit db, int idx, int n);
    if (fm == 3) return db ? (idx == 0) : (idx == n - 1);
    if (fm == 0) return ((idx + 1) % n) >= n / 2;
    return idx < n / 2;
  endfunction

  task automatic wait_fs();
    do step(); while (!frame_start);
  endtask

  task automatic wr(input logic [15:0] v);
    if (running_b) wait_fs();
    cfg_we = 1'b1;
    cfg_wdata = v;
    step();
    cfg_we = 1'b0;
    running_b = v[15] && (v[12:9] <= 4'd13) && (v[8:6] <= 3'd4);
  endtask

  task automatic meas(input bit ib, output int per, output int hi);
    bit p, c;
    p = bclk_out ^ ib;
    forever begin
      step();
      c = bclk_out ^ ib;
      if (!p && c) break;
      p = c;
    end
    per = 0; hi = 1; p = 1'b1;
    forever begin
      step();
      per++;
      c = bclk_out ^ ib;
      if (!p && c) break;
      if (c) hi++;
      p = c;
    end
  endtask

  task automatic cap(input bit ib, output logic [255:0] pat, output int nb, output bit first_b);
    bit p, c;
    wait_fs();
    first_b = bclk_out;
    p = bclk_out ^ ib;
    nb = 0;
    pat = '0;
    forever begin
      step();
      if (frame_start) break;
      c = bclk_out ^ ib;
      if (!p && c) begin
        if (nb < 256) pat[nb] = lrck_out;
        nb++;
      end
      p = c;
    end
  endtask

  function automatic int pat_miss(logic [255:0] pat, int n, int fm, bit db, bit il);
    int miss = 0;
    for (int i = 0; i < n; i++) begin
      bit e = exp_lr(fm, db, i, n) ^ (il && fm != 3);
      if (pat[i] != e) miss++;
    end
    return miss;
  endfunction

  task automatic drv(input int fm, input bit db, input bit il, input bit ib,
                     input int nfr, output int hits);
    int n = 16;
    bit idle = (fm == 0);
    hits = 0;
    for (int b = 0; b < 4 + nfr * n + 2; b++) begin
      bit lev;
      if (b < 4 || b >= 4 + nfr * n) lev = idle;
      else lev = exp_lr(fm, db, (b - 4) % n, n);
      lrck_in = lev ^ (il && fm != 3);
      bclk_in = ib;
      repeat (4) begin step(); if (frame_start) hits++; end
      bclk_in = ~ib;
      repeat (4) begin step(); if (frame_start) hits++; end
    end
    repeat (12) begin step(); if (frame_start) hits++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int per, hi, nb, hits, cnt, bad;
    logic [255:0] pat;
    bit fb;

    repeat (5) step();
    rst_n = 1'b1;
    step();
    // R1: reset state
    chk("R1 bclk_oe", int'(bclk_oe), 0);
    chk("R1 bclk_out", int'(bclk_out), 0);
    chk("R1 lrck_out", int'(lrck_out), 0);
    chk("R1 frame_start", int'(frame_start), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);

    // R2: every divider code
    for (int bd = 0; bd < 14; bd++) begin
      wr(mk(1, 0, 0, bd, 0, 0, 1));
      wait_fs();
      meas(1'b0, per, hi);
      chk($sformatf("R2 period code %0d", bd), per, 2 * ratio_tab[bd]);
      chk($sformatf("R2 high time code %0d", bd), hi, ratio_tab[bd]);
    end

    // R3: every frame length
    for (int fl = 0; fl < 5; fl++) begin
      wr(mk(1, 0, 0, 0, fl, 0, 1));
      cap(1'b0, pat, nb, fb);
      chk($sformatf("R3 bits per frame code %0d", fl), nb, 16 << fl);
      chk($sformatf("R3 frame shape code %0d", fl), pat_miss(pat, 16 << fl, 1, 0, 0), 0);
    end

    // R4 R5 R6 R7: formats and polarity
    for (int fm = 0; fm < 4; fm++) begin
      for (int il = 0; il < 2; il++) begin
        for (int ib = 0; ib < 2; ib++) begin
          wr(mk(1, il[0], ib[0], 0, 0, (fm + il) % 4, fm));
          cap(ib[0], pat, nb, fb);
          chk((fm == 3) ? "R6 dsp frame bits" : (fm == 0) ? "R5 i2s frame bits" : "R4 justified frame bits", nb, 16);
          chk((fm == 3) ? "R6 dsp pulse" : (fm == 0) ? "R5 i2s frame shape" : "R4 justified frame shape",
              pat_miss(pat, 16, fm, il[0], il[0]), 0);
          chk("R7 bit clock level at frame start", int'(fb), ib);
        end
      end
    end

    // R12: word size has no effect
    for (int ws = 0; ws < 4; ws++) begin
      wr(mk(1, 0, 0, 0, 1, ws, 2));
      cap(1'b0, pat, nb, fb);
      chk($sformatf("R12 frame with word size %0d", ws), pat_miss(pat, 32, 2, 0, 0) + (nb - 32), 0);
    end

    // R10: one pulse per frame
    wr(mk(1, 0, 0, 0, 0, 0, 1));
    wait_fs();
    cnt = 0;
    repeat (96) begin step(); if (frame_start) cnt++; end
    chk("R10 frame pulses in three frames", cnt, 3);

    // R9: a change while running waits for the frame boundary
    wr(mk(1, 0, 0, 2, 0, 0, 1));
    wait_fs();
    wr(mk(1, 0, 0, 0, 0, 0, 1));
    meas(1'b0, per, hi);
    chk("R9 old divider kept mid-frame", per, 8);
    wait_fs();
    meas(1'b0, per, hi);
    chk("R9 new divider after boundary", per, 2);

    // R8: reserved codes stop the clocks
    wr(mk(1, 1, 1, 14, 0, 0, 1));
    repeat (40) step();
    chk("R8 error on divider code 14", int'(cfg_err), 1);
    bad = 0;
    repeat (20) begin
      step();
      if (bclk_out !== 1'b1 || lrck_out !== 1'b1 || frame_start !== 1'b0) bad++;
    end
    chk("R8 clocks frozen at polarity levels", bad, 0);
    wr(mk(1, 0, 0, 15, 0, 0, 1));
    step();
    chk("R8 error on divider code 15", int'(cfg_err), 1);
    chk("R8 bit clock idle low", int'(bclk_out), 0);
    wr(mk(1, 0, 0, 0, 5, 0, 1));
    step();
    chk("R8 error on frame code 5", int'(cfg_err), 1);
    wr(mk(1, 0, 0, 0, 0, 0, 1));
    chk("R9 error still set before load edge", int'(cfg_err), 1);
    step();
    chk("R9 immediate load while stopped", int'(cfg_err), 0);

    // R11: slave mode
    wr(mk(0, 0, 0, 0, 0, 0, 1));
    repeat (40) step();
    chk("R11 slave bclk_oe", int'(bclk_oe), 0);
    chk("R11 slave bclk_out", int'(bclk_out), 0);
    chk("R11 slave lrck_out", int'(lrck_out), 0);
    drv(1, 0, 0, 0, 3, hits);
    chk("R11 slave justified frames", hits, 3);
    wr(mk(0, 1, 1, 0, 0, 0, 0));
    drv(0, 0, 1, 1, 3, hits);
    // the falling edge that closes the last frame counts as one more start
    chk("R11 slave i2s inverted frames", hits, 4);
    wr(mk(0, 0, 0, 0, 0, 0, 3));
    drv(3, 0, 0, 0, 3, hits);
    chk("R11 slave dsp A frames", hits, 3);
    wr(mk(0, 1, 0, 0, 0, 0, 3));
    drv(3, 1, 1, 0, 3, hits);
    chk("R11 slave dsp B frames", hits, 3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule